// File: doc/BRIEF.md
# Decode Group Former

This block sits between an instruction buffer and a micro-op scheduler. Each decode clock it looks at the first two descriptors waiting in the buffer. Each descriptor has already been classified and carries:

- a byte length,
- a class code,
- a count of micro-op templates,
- up to four templates.

All three decode paths (dual short, single long, vector hand-off) evaluate the same two descriptors in parallel. Exactly one path is allowed to produce the group for that clock.

Whatever path wins, the block emits one registered group of four micro-op slots. Slots the decode does not fill carry the NOP encoding (all zeros). The group also carries a per-slot fill mask, the chosen path code and the number of buffer bytes consumed. The fetch stage uses that byte count to advance the buffer.

Both sides of the block use valid/ready. A stalled output holds its group, and no new bytes are consumed while it is held.

Top module: `dgf_top`

## Requirements
- R1: After reset, `grp_valid` is 0 and `in_ready` is 1.
- R2: Class codes are SHORT=0, ESC=1, MMX=2, LONG=3, COMPLEX=4. Path codes are DUAL=0, SINGLE=1, LONG=2, VECTOR=3. When both descriptors are short-qualified and may pair, the path is DUAL. Slots are filled in order: the first descriptor's ops, then the second's. `grp_bytes` is the sum of the two lengths.
- R3: A descriptor of class ESC is never decoded in the second short slot. With ESC second, the path is SINGLE and only the first descriptor is consumed.
- R4: When the first short slot holds ESC, an MMX descriptor in the second slot is not paired. The path is SINGLE.
- R5: A LONG descriptor with length 1..11 and 1..4 ops takes the LONG path. That path decodes one descriptor only, and `grp_bytes` equals its length.
- R6: Every group has four slots. Slot i is filled (mask bit i = 1) for i below the number of decoded ops. Every other slot holds 0 and has a 0 mask bit.
- R7: A COMPLEX descriptor, or any descriptor no other path accepts (for example a LONG with length 12 or more, or zero ops), goes to the VECTOR path. That path emits the descriptor's first min(ops,4) templates.
- R8: With `in_trap` high, the path is VECTOR with all four slots NOP, a mask of 0 and 0 bytes consumed.
- R9: While `grp_valid`=1 and `grp_ready`=0, `in_ready` is 0 and every group output stays unchanged.
- R10: A short-class descriptor (SHORT, ESC or MMX) qualifies for the short path only with length 1..7 and 1..2 ops. Otherwise it goes to the VECTOR path.
- R11: For every accepted descriptor, exactly one of the four path selects is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | First descriptor present |
| in_ready | output | 1 | Block can take a decode this clock |
| in_trap | input | 1 | Pending interrupt or exception; forces vector hand-off |
| a_cls | input | 3 | First descriptor class code |
| a_len | input | 4 | First descriptor length in bytes |
| a_nops | input | 3 | First descriptor op count |
| a_ops | input | 64 | First descriptor op templates, op 0 in bits 15:0 |
| b_valid | input | 1 | Second descriptor present |
| b_cls | input | 3 | Second descriptor class code |
| b_len | input | 4 | Second descriptor length in bytes |
| b_nops | input | 3 | Second descriptor op count |
| b_ops | input | 64 | Second descriptor op templates |
| grp_valid | output | 1 | Group present |
| grp_ready | input | 1 | Scheduler takes the group |
| grp_path | output | 2 | Path code that formed the group |
| grp_mask | output | 4 | Per-slot fill mask |
| grp_ops | output | 64 | Four micro-op slots, slot 0 in bits 15:0 |
| grp_bytes | output | 5 | Buffer bytes consumed by this group |

## Verification
The hardest situation to reach from the ports is a stall where new descriptors are already waiting. The held group must not change, and no bytes may be consumed until the scheduler frees the output. The stimulus captures one group, then drops `grp_ready` and presents a different descriptor pair. It checks that the old group and a low `in_ready` persist. It then releases the stall and checks that the waiting pair is decoded on the very edge that frees the output.

The pairing corners are covered by table rows:
- ESC in the second slot,
- ESC followed by MMX,
- a short class with too many ops or bytes,
- a trap on top of a decodable pair.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  typedef enum logic [2:0] {
    CLS_SHORT = 3'd0,
    CLS_ESC   = 3'd1,
    CLS_MMX   = 3'd2,
    CLS_LONG  = 3'd3,
    CLS_CPLX  = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    PATH_DUAL   = 2'd0,
    PATH_SINGLE = 2'd1,
    PATH_LONG   = 2'd2,
    PATH_VECTOR = 2'd3
  } path_e;
endpackage

// File: rtl/dgf_classify.sv
module dgf_classify #(
  parameter int LEN_W         = 4,
  parameter int NOPS_W        = 3,
  parameter int SHORT_MAX_LEN = 7,
  parameter int LONG_MAX_LEN  = 11,
  parameter int SHORT_MAX_OPS = 2,
  parameter int SLOTS         = 4
) (
  input  logic [2:0]        cls,
  input  logic [LEN_W-1:0]  len,
  input  logic [NOPS_W-1:0] nops,
  output logic              short_ok,
  output logic              long_ok,
  output logic              is_esc,
  output logic              is_mmx
);
  import dgf_pkg::*;

  localparam logic [LEN_W-1:0]  S_LEN = LEN_W'(SHORT_MAX_LEN);
  localparam logic [LEN_W-1:0]  L_LEN = LEN_W'(LONG_MAX_LEN);
  localparam logic [NOPS_W-1:0] S_OPS = NOPS_W'(SHORT_MAX_OPS);
  localparam logic [NOPS_W-1:0] L_OPS = NOPS_W'(SLOTS);

  logic short_cls;
  logic len_nz;
  logic ops_nz;

  always_comb begin
    is_esc    = (cls == CLS_ESC);
    is_mmx    = (cls == CLS_MMX);
    short_cls = (cls == CLS_SHORT) || is_esc || is_mmx;
    len_nz    = (len != '0);
    ops_nz    = (nops != '0);
    short_ok  = short_cls && len_nz && (len <= S_LEN) && ops_nz && (nops <= S_OPS);
    long_ok   = (cls == CLS_LONG) && len_nz && (len <= L_LEN) && ops_nz && (nops <= L_OPS);
  end
endmodule

// File: rtl/dgf_select.sv
module dgf_select #(
  parameter int LEN_W  = 4,
  parameter int NOPS_W = 3,
  parameter int SLOTS  = 4,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int BYT_W = LEN_W + 1
) (
  input  logic              trap,
  input  logic              a_short_ok,
  input  logic              a_long_ok,
  input  logic              a_esc,
  input  logic [NOPS_W-1:0] a_nops,
  input  logic [LEN_W-1:0]  a_len,
  input  logic              b_valid,
  input  logic              b_short_ok,
  input  logic              b_esc,
  input  logic              b_mmx,
  input  logic [NOPS_W-1:0] b_nops,
  input  logic [LEN_W-1:0]  b_len,
  output logic              sel_dual,
  output logic              sel_single,
  output logic              sel_long,
  output logic              sel_vec,
  output logic [1:0]        path,
  output logic [CNT_W-1:0]  na,
  output logic [CNT_W-1:0]  nb,
  output logic [BYT_W-1:0]  bytes
);
  import dgf_pkg::*;

  localparam logic [NOPS_W-1:0] CAP = NOPS_W'(SLOTS);

  logic             pair_ok;
  logic [CNT_W-1:0] a_cnt;

  always_comb begin
    // second slot never takes ESC; after an ESC first slot it never takes MMX
    pair_ok    = b_valid && a_short_ok && b_short_ok && !b_esc && !(a_esc && b_mmx);
    sel_dual   = !trap && pair_ok;
    sel_single = !trap && a_short_ok && !pair_ok;
    sel_long   = !trap && a_long_ok;
    sel_vec    = trap || (!a_short_ok && !a_long_ok);

    a_cnt = (a_nops > CAP) ? CNT_W'(SLOTS) : CNT_W'(a_nops);

    path  = PATH_VECTOR;
    na    = '0;
    nb    = '0;
    bytes = '0;
    if (sel_dual) begin
      path  = PATH_DUAL;
      na    = a_cnt;
      nb    = CNT_W'(b_nops);
      bytes = BYT_W'(a_len) + BYT_W'(b_len);
    end else if (sel_single) begin
      path  = PATH_SINGLE;
      na    = a_cnt;
      bytes = BYT_W'(a_len);
    end else if (sel_long) begin
      path  = PATH_LONG;
      na    = a_cnt;
      bytes = BYT_W'(a_len);
    end else if (!trap) begin
      path  = PATH_VECTOR;
      na    = a_cnt;
      bytes = BYT_W'(a_len);
    end
  end
endmodule

// File: rtl/dgf_pack.sv
module dgf_pack #(
  parameter int OP_W   = 16,
  parameter int SLOTS  = 4,
  parameter logic [OP_W-1:0] NOP_OP = '0,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*OP_W-1:0] a_ops,
  input  logic [SLOTS*OP_W-1:0] b_ops,
  input  logic [CNT_W-1:0]      na,
  input  logic [CNT_W-1:0]      nb,
  output logic [SLOTS*OP_W-1:0] slot_ops,
  output logic [SLOTS-1:0]      slot_mask
);
  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    logic [OP_W-1:0] op_sel;
    logic            filled;

    always_comb begin
      op_sel = NOP_OP;
      filled = 1'b0;
      if (CNT_W'(gi) < na) begin
        op_sel = a_ops[gi*OP_W +: OP_W];
        filled = 1'b1;
      end else begin
        for (int j = 0; j < SLOTS; j++) begin
          if ((CNT_W'(j) < nb) && ((na + CNT_W'(j)) == CNT_W'(gi))) begin
            op_sel = b_ops[j*OP_W +: OP_W];
            filled = 1'b1;
          end
        end
      end
    end

    assign slot_ops[gi*OP_W +: OP_W] = op_sel;
    assign slot_mask[gi]             = filled;
  end
endmodule

// File: rtl/dgf_top.sv
module dgf_top #(
  parameter int OP_W          = 16,
  parameter int SLOTS         = 4,
  parameter int LEN_W         = 4,
  parameter int NOPS_W        = 3,
  parameter int SHORT_MAX_LEN = 7,
  parameter int LONG_MAX_LEN  = 11,
  parameter int SHORT_MAX_OPS = 2,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int BYT_W = LEN_W + 1,
  localparam int GRP_W = SLOTS * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_trap,
  input  logic [2:0]        a_cls,
  input  logic [LEN_W-1:0]  a_len,
  input  logic [NOPS_W-1:0] a_nops,
  input  logic [GRP_W-1:0]  a_ops,
  input  logic              b_valid,
  input  logic [2:0]        b_cls,
  input  logic [LEN_W-1:0]  b_len,
  input  logic [NOPS_W-1:0] b_nops,
  input  logic [GRP_W-1:0]  b_ops,
  output logic              grp_valid,
  input  logic              grp_ready,
  output logic [1:0]        grp_path,
  output logic [SLOTS-1:0]  grp_mask,
  output logic [GRP_W-1:0]  grp_ops,
  output logic [BYT_W-1:0]  grp_bytes
);
  import dgf_pkg::*;

  localparam logic [OP_W-1:0] NOP_OP = '0;

  logic a_short_ok, a_long_ok, a_esc, a_mmx;
  logic b_short_ok, b_long_ok, b_esc, b_mmx;
  logic sel_dual, sel_single, sel_long, sel_vec;
  logic [1:0]       path_c;
  logic [CNT_W-1:0] na_c, nb_c;
  logic [BYT_W-1:0] bytes_c;
  logic [GRP_W-1:0] ops_c;
  logic [SLOTS-1:0] mask_c;

  dgf_classify #(
    .LEN_W(LEN_W), .NOPS_W(NOPS_W), .SHORT_MAX_LEN(SHORT_MAX_LEN),
    .LONG_MAX_LEN(LONG_MAX_LEN), .SHORT_MAX_OPS(SHORT_MAX_OPS), .SLOTS(SLOTS)
  ) u_cls_a (
    .cls(a_cls), .len(a_len), .nops(a_nops),
    .short_ok(a_short_ok), .long_ok(a_long_ok), .is_esc(a_esc), .is_mmx(a_mmx)
  );

  dgf_classify #(
    .LEN_W(LEN_W), .NOPS_W(NOPS_W), .SHORT_MAX_LEN(SHORT_MAX_LEN),
    .LONG_MAX_LEN(LONG_MAX_LEN), .SHORT_MAX_OPS(SHORT_MAX_OPS), .SLOTS(SLOTS)
  ) u_cls_b (
    .cls(b_cls), .len(b_len), .nops(b_nops),
    .short_ok(b_short_ok), .long_ok(b_long_ok), .is_esc(b_esc), .is_mmx(b_mmx)
  );

  dgf_select #(.LEN_W(LEN_W), .NOPS_W(NOPS_W), .SLOTS(SLOTS)) u_sel (
    .trap(in_trap),
    .a_short_ok(a_short_ok), .a_long_ok(a_long_ok), .a_esc(a_esc),
    .a_nops(a_nops), .a_len(a_len),
    .b_valid(b_valid), .b_short_ok(b_short_ok), .b_esc(b_esc), .b_mmx(b_mmx),
    .b_nops(b_nops), .b_len(b_len),
    .sel_dual(sel_dual), .sel_single(sel_single), .sel_long(sel_long), .sel_vec(sel_vec),
    .path(path_c), .na(na_c), .nb(nb_c), .bytes(bytes_c)
  );

  dgf_pack #(.OP_W(OP_W), .SLOTS(SLOTS), .NOP_OP(NOP_OP)) u_pack (
    .a_ops(a_ops), .b_ops(b_ops), .na(na_c), .nb(nb_c),
    .slot_ops(ops_c), .slot_mask(mask_c)
  );

  // output stage: next-state logic and registers kept apart
  logic             fire;
  logic             valid_d;
  logic             load_en;
  logic [1:0]       path_d;
  logic [SLOTS-1:0] mask_d;
  logic [GRP_W-1:0] ops_d;
  logic [BYT_W-1:0] bytes_d;

  always_comb begin
    in_ready = !grp_valid || grp_ready;
    fire     = in_valid && in_ready;
    load_en  = fire;
    if (fire)           valid_d = 1'b1;
    else if (grp_ready) valid_d = 1'b0;
    else                valid_d = grp_valid;
    path_d  = path_c;
    mask_d  = mask_c;
    ops_d   = ops_c;
    bytes_d = bytes_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_valid <= 1'b0;
    else        grp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_path  <= PATH_VECTOR;
      grp_mask  <= '0;
      grp_ops   <= '0;
      grp_bytes <= '0;
    end else if (load_en) begin
      grp_path  <= path_d;
      grp_mask  <= mask_d;
      grp_ops   <= ops_d;
      grp_bytes <= bytes_d;
    end
  end

  // checks on the path selection
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot({sel_dual, sel_single, sel_long, sel_vec})); // R11
  AST_ESC_NOT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_dual) |-> (b_cls != CLS_ESC)); // R3
  AST_MMX_AFTER_ESC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_dual && a_cls == CLS_ESC) |-> (b_cls != CLS_MMX)); // R4

  // checks on the output stage
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_ready) |=> (grp_valid && $stable(grp_ops) && $stable(grp_bytes)
                                   && $stable(grp_mask) && $stable(grp_path))); // R9
  AST_TRAP_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_trap) |=> (grp_bytes == '0 && grp_mask == '0)); // R8

  for (genvar gs = 0; gs < SLOTS; gs++) begin : g_ast_pad
    AST_NOP_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_valid && !grp_mask[gs]) |-> (grp_ops[gs*OP_W +: OP_W] == NOP_OP)); // R6
  end
endmodule

// File: tb/sim_dgf_top.sv
module sim_dgf_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        in_valid, in_ready, in_trap, b_valid, grp_valid, grp_ready;
  logic [2:0]  a_cls, b_cls, a_nops, b_nops;
  logic [3:0]  a_len, b_len, grp_mask;
  logic [63:0] a_ops, b_ops, grp_ops;
  logic [1:0]  grp_path;
  logic [4:0]  grp_bytes;

  dgf_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_trap(in_trap),
    .a_cls(a_cls), .a_len(a_len), .a_nops(a_nops), .a_ops(a_ops),
    .b_valid(b_valid), .b_cls(b_cls), .b_len(b_len), .b_nops(b_nops), .b_ops(b_ops),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_path(grp_path),
    .grp_mask(grp_mask), .grp_ops(grp_ops), .grp_bytes(grp_bytes)
  );

  localparam logic [63:0] A_OPS = 64'hA004_A003_A002_A001;
  localparam logic [63:0] B_OPS = 64'hB004_B003_B002_B001;

  typedef struct packed {
    logic [2:0] acls; logic [3:0] alen; logic [2:0] anops;
    logic       bval; logic [2:0] bcls; logic [3:0] blen; logic [2:0] bnops;
    logic       trap;
    logic [1:0] path; logic [2:0] na; logic [2:0] nb; logic [4:0] bytes;
    logic [7:0] req;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t ROWS [NROWS] = '{
    '{3'd0,4'd3,3'd1, 1'b1,3'd0,4'd2,3'd2, 1'b0, 2'd0,3'd1,3'd2,5'd5,   8'd2},  // R2 short+short
    '{3'd1,4'd2,3'd2, 1'b1,3'd0,4'd4,3'd2, 1'b0, 2'd0,3'd2,3'd2,5'd6,   8'd2},  // R2 ESC+short
    '{3'd0,4'd3,3'd2, 1'b1,3'd1,4'd2,3'd1, 1'b0, 2'd1,3'd2,3'd0,5'd3,   8'd3},  // R3 ESC second
    '{3'd1,4'd2,3'd1, 1'b1,3'd2,4'd3,3'd1, 1'b0, 2'd1,3'd1,3'd0,5'd2,   8'd4},  // R4 ESC then MMX
    '{3'd2,4'd3,3'd1, 1'b1,3'd0,4'd1,3'd1, 1'b0, 2'd0,3'd1,3'd1,5'd4,   8'd2},  // R2 MMX+short
    '{3'd3,4'd11,3'd3,1'b1,3'd0,4'd2,3'd1, 1'b0, 2'd2,3'd3,3'd0,5'd11,  8'd5},  // R5 long 11 bytes
    '{3'd3,4'd5,3'd4, 1'b0,3'd0,4'd0,3'd0, 1'b0, 2'd2,3'd4,3'd0,5'd5,   8'd5},  // R5 long 4 ops
    '{3'd4,4'd6,3'd7, 1'b1,3'd0,4'd2,3'd1, 1'b0, 2'd3,3'd4,3'd0,5'd6,   8'd7},  // R7 complex clamp
    '{3'd0,4'd8,3'd1, 1'b1,3'd0,4'd2,3'd1, 1'b0, 2'd3,3'd1,3'd0,5'd8,   8'd10}, // R10 short too long
    '{3'd0,4'd2,3'd3, 1'b1,3'd0,4'd2,3'd1, 1'b0, 2'd3,3'd3,3'd0,5'd2,   8'd10}, // R10 short too many ops
    '{3'd0,4'd2,3'd1, 1'b0,3'd0,4'd2,3'd1, 1'b0, 2'd1,3'd1,3'd0,5'd2,   8'd6},  // R6 lone short padding
    '{3'd0,4'd3,3'd1, 1'b1,3'd0,4'd2,3'd1, 1'b1, 2'd3,3'd0,3'd0,5'd0,   8'd8},  // R8 trap
    '{3'd3,4'd12,3'd2,1'b0,3'd0,4'd0,3'd0, 1'b0, 2'd3,3'd2,3'd0,5'd12,  8'd7},  // R7 long too long
    '{3'd0,4'd1,3'd1, 1'b1,3'd3,4'd9,3'd2, 1'b0, 2'd1,3'd1,3'd0,5'd1,   8'd6}   // R6 short then long
  };

  int checks = 0;
  int errors = 0;

  function automatic logic [63:0] exp_ops(input int na, input int nb);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < na)           r[i*16 +: 16] = A_OPS[i*16 +: 16];
      else if (i < na + nb) r[i*16 +: 16] = B_OPS[(i-na)*16 +: 16];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    a_cls = r.acls; a_len = r.alen; a_nops = r.anops;
    b_valid = r.bval; b_cls = r.bcls; b_len = r.blen; b_nops = r.bnops;
    in_trap = r.trap; in_valid = 1'b1;
  endtask

  task automatic check_row(input row_t r);
    string t;
    t = $sformatf("R%0d", r.req);
    chk({t, " valid"}, 64'(grp_valid), 64'd1);
    chk({t, " path"},  64'(grp_path),  64'(r.path));
    chk({t, " mask"},  64'(grp_mask),  64'((4'b1 << (r.na + r.nb)) - 4'b1));
    chk({t, " ops"},   grp_ops,        exp_ops(int'(r.na), int'(r.nb)));
    chk({t, " bytes"}, 64'(grp_bytes), 64'(r.bytes));
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_trap = 1'b0; grp_ready = 1'b1;
    a_cls = '0; a_len = '0; a_nops = '0; a_ops = A_OPS;
    b_valid = 1'b0; b_cls = '0; b_len = '0; b_nops = '0; b_ops = B_OPS;
    repeat (3) @(negedge clk);
    chk("R1 reset grp_valid", 64'(grp_valid), 64'd0);
    chk("R1 reset in_ready",  64'(in_ready),  64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: one row accepted per edge
    drive(ROWS[0]);
    for (int k = 0; k < NROWS; k++) begin
      @(negedge clk);
      check_row(ROWS[k]);
      if (k + 1 < NROWS) drive(ROWS[k+1]);
    end

    // idle: valid drops when nothing is offered
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle drops valid", 64'(grp_valid), 64'd0);

    // stall with new descriptors waiting (R9)
    drive(ROWS[0]);
    @(negedge clk);
    check_row(ROWS[0]);
    grp_ready = 1'b0;
    drive(ROWS[5]);
    @(negedge clk);
    chk("R9 stall in_ready low", 64'(in_ready), 64'd0);
    check_row(ROWS[0]);
    @(negedge clk);
    check_row(ROWS[0]);
    grp_ready = 1'b1;
    @(negedge clk);
    check_row(ROWS[5]);
    in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule